// File: doc/BRIEF.md
# Three-Product Complex Multiplier

This block rotates a complex sample by a complex coefficient, as an FFT stage needs when it applies a twiddle factor. It takes signed real and imaginary parts of a data word and of a coefficient, marked by a valid strobe. It returns the exact complex product at full precision, marked by its own valid strobe.

Only three real multiplications are used where the schoolbook form needs four. The imaginary part is the sum of the two cross products Dr·Ci and Di·Cr. The real part is the product of the data pre-sum (Dr+Di) and the coefficient pre-difference (Cr−Ci), corrected by adding the difference of those same two cross products. The saved multiplier is paid for with a few adders and subtractors.

The datapath has three register stages: pre-add, multiply and post-combine. Results appear a fixed number of cycles after their operands, and a new operand set may enter on every cycle. No rounding or scaling is applied.

Top module: `cmul3`

## Requirements
- R1: The imaginary output equals Dr·Ci + Di·Cr, exact in two's complement at width DW+CW+2.
- R2: The real output equals Dr·Cr − Di·Ci, exact at width DW+CW+2, although it is formed as (Dr+Di)·(Cr−Ci) + (Dr·Ci − Di·Cr).
- R3: The pre-sum Dr+Di and the pre-difference Cr−Ci are each one bit wider than their inputs. At the most negative and most positive input values they do not wrap, and the results stay exact.
- R4: Each of the three products keeps full width with no overflow, including when both pre-add operands sit at their extreme values (for example (−2·2^(DW−1))·(2^CW−1)).
- R5: out_valid is high exactly 3 clock cycles after in_valid was sampled high, and low 3 cycles after it was sampled low.
- R6: Operand sets presented on consecutive cycles produce results on consecutive cycles, each matching its own operands.
- R7: While out_valid is low, r_re and r_im hold the last valid result. Operands presented with in_valid low have no effect on them.
- R8: A synchronous active-high reset clears out_valid and drives r_re and r_im to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set present this cycle |
| d_re | input | DW | Data real part, signed |
| d_im | input | DW | Data imaginary part, signed |
| c_re | input | CW | Coefficient real part, signed |
| c_im | input | CW | Coefficient imaginary part, signed |
| out_valid | output | 1 | Result present this cycle |
| r_re | output | DW+CW+2 | Real part of product, signed |
| r_im | output | DW+CW+2 | Imaginary part of product, signed |

## Verification
In a single cycle the pipeline can accept a fresh operand set at the pre-adder while it also retires an older result at the output. An idle input can likewise coincide with a result that must keep holding. Random valid patterns with gaps of random length, together with an unbroken burst, make accepting, retiring and holding happen in the same cycles. Each output cycle is compared with the operands issued three cycles earlier, or with the last valid result when that slot was empty. The expected values come from the direct four-product formula.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;

  // register stages between operand capture and result
  localparam int unsigned CMUL3_LAT = 3;

  // full-precision output width for the given operand widths
  function automatic int prod_width(input int dw, input int cw);
    return dw + cw + 2;
  endfunction

endpackage

// File: rtl/cmul3_preadd.sv
module cmul3_preadd #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_in,
  input  logic signed [DW-1:0] dr,
  input  logic signed [DW-1:0] di,
  input  logic signed [CW-1:0] cr,
  input  logic signed [CW-1:0] ci,
  output logic                 v_q,
  output logic signed [DW:0]   dsum_q,
  output logic signed [CW:0]   cdif_q,
  output logic signed [DW-1:0] dr_q,
  output logic signed [DW-1:0] di_q,
  output logic signed [CW-1:0] cr_q,
  output logic signed [CW-1:0] ci_q
);

  function automatic logic signed [DW:0] grow_add(input logic signed [DW-1:0] a,
                                                  input logic signed [DW-1:0] b);
    return {a[DW-1], a} + {b[DW-1], b};
  endfunction

  function automatic logic signed [CW:0] grow_sub(input logic signed [CW-1:0] a,
                                                  input logic signed [CW-1:0] b);
    return {a[CW-1], a} - {b[CW-1], b};
  endfunction

  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q     <= 1'b0;
      armed_q <= 1'b0;
      dsum_q  <= '0;
      cdif_q  <= '0;
      dr_q    <= '0;
      di_q    <= '0;
      cr_q    <= '0;
      ci_q    <= '0;
    end else begin
      v_q     <= v_in;
      armed_q <= 1'b1;
      if (v_in) begin
        dsum_q <= grow_add(dr, di);
        cdif_q <= grow_sub(cr, ci);
        dr_q   <= dr;
        di_q   <= di;
        cr_q   <= cr;
        ci_q   <= ci;
      end
    end
  end

  // R3: the widened pre-sum recovers its addend, so no wrap occurred
  assert_presum_exact_R3: assert property (@(posedge clk) disable iff (rst)
    armed_q && $past(v_in) |-> (dsum_q - dr_q) == di_q);

  // R3: the widened pre-difference recovers its subtrahend
  assert_predif_exact_R3: assert property (@(posedge clk) disable iff (rst)
    armed_q && $past(v_in) |-> (cr_q - cdif_q) == ci_q);

endmodule

// File: rtl/cmul3_mul.sv
module cmul3_mul #(
  parameter int AW = 17,
  parameter int BW = 17
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [AW-1:0]    a,
  input  logic signed [BW-1:0]    b,
  output logic signed [AW+BW-1:0] p_q
);

  localparam int PW = AW + BW;

  function automatic logic signed [PW-1:0] full_mul(input logic signed [AW-1:0] x,
                                                   input logic signed [BW-1:0] y);
    logic signed [PW-1:0] xw;
    logic signed [PW-1:0] yw;
    xw = {{BW{x[AW-1]}}, x};
    yw = {{AW{y[BW-1]}}, y};
    return xw * yw;
  endfunction

  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q     <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (en) p_q <= full_mul(a, b);
    end
  end

  // R4: a nonzero product carries the sign of its operands, so it did not overflow
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    armed_q && $past(en) && ($past(a) != '0) && ($past(b) != '0)
    |-> p_q[PW-1] == ($past(a[AW-1]) ^ $past(b[BW-1])));

endmodule

// File: rtl/cmul3_post.sv
module cmul3_post #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       v_in,
  input  logic signed [DW+CW+1:0]    p_main,
  input  logic signed [DW+CW-1:0]    p_rc,
  input  logic signed [DW+CW-1:0]    p_ir,
  output logic                       v_q,
  output logic signed [DW+CW+1:0]    re_q,
  output logic signed [DW+CW+1:0]    im_q
);

  localparam int OW = DW + CW + 2;
  localparam int XW = DW + CW;

  function automatic logic signed [OW-1:0] widen(input logic signed [XW-1:0] x);
    return {{(OW-XW){x[XW-1]}}, x};
  endfunction

  logic signed [OW-1:0] rc_w;
  logic signed [OW-1:0] ir_w;
  logic signed [OW-1:0] corr;
  logic signed [OW-1:0] re_d;
  logic signed [OW-1:0] im_d;

  always_comb begin
    rc_w = widen(p_rc);
    ir_w = widen(p_ir);
    corr = rc_w - ir_w;
    re_d = p_main + corr;
    im_d = rc_w + ir_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q  <= 1'b0;
      re_q <= '0;
      im_q <= '0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        re_q <= re_d;
        im_q <= im_d;
      end
    end
  end

endmodule

// File: rtl/cmul3.sv
module cmul3 #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [DW-1:0]    d_re,
  input  logic signed [DW-1:0]    d_im,
  input  logic signed [CW-1:0]    c_re,
  input  logic signed [CW-1:0]    c_im,
  output logic                    out_valid,
  output logic signed [DW+CW+1:0] r_re,
  output logic signed [DW+CW+1:0] r_im
);

  import cmul3_pkg::*;

  localparam int OW   = prod_width(DW, CW);
  localparam int AGEW = $clog2(CMUL3_LAT + 1);
  localparam logic [AGEW-1:0] AGE_MAX = AGEW'(CMUL3_LAT);

  // stage 1 outputs
  logic                 s1_v;
  logic signed [DW:0]   s1_dsum;
  logic signed [CW:0]   s1_cdif;
  logic signed [DW-1:0] s1_dr;
  logic signed [DW-1:0] s1_di;
  logic signed [CW-1:0] s1_cr;
  logic signed [CW-1:0] s1_ci;

  // stage 2 outputs
  logic                    s2_v;
  logic signed [OW-1:0]    s2_main;
  logic signed [DW+CW-1:0] s2_rc;
  logic signed [DW+CW-1:0] s2_ir;

  cmul3_preadd #(.DW(DW), .CW(CW)) u_pre (
    .clk(clk), .rst(rst), .v_in(in_valid),
    .dr(d_re), .di(d_im), .cr(c_re), .ci(c_im),
    .v_q(s1_v), .dsum_q(s1_dsum), .cdif_q(s1_cdif),
    .dr_q(s1_dr), .di_q(s1_di), .cr_q(s1_cr), .ci_q(s1_ci)
  );

  // three real multipliers: one wide, two cross products
  cmul3_mul #(.AW(DW+1), .BW(CW+1)) u_mul_main (
    .clk(clk), .rst(rst), .en(s1_v), .a(s1_dsum), .b(s1_cdif), .p_q(s2_main)
  );

  cmul3_mul #(.AW(DW), .BW(CW)) u_mul_rc (
    .clk(clk), .rst(rst), .en(s1_v), .a(s1_dr), .b(s1_ci), .p_q(s2_rc)
  );

  cmul3_mul #(.AW(DW), .BW(CW)) u_mul_ir (
    .clk(clk), .rst(rst), .en(s1_v), .a(s1_di), .b(s1_cr), .p_q(s2_ir)
  );

  always_ff @(posedge clk) begin
    if (rst) s2_v <= 1'b0;
    else     s2_v <= s1_v;
  end

  cmul3_post #(.DW(DW), .CW(CW)) u_post (
    .clk(clk), .rst(rst), .v_in(s2_v),
    .p_main(s2_main), .p_rc(s2_rc), .p_ir(s2_ir),
    .v_q(out_valid), .re_q(r_re), .im_q(r_im)
  );

  // ---------------- checking aids ----------------
  // edges since reset release, saturating at the latency
  logic [AGEW-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst)                 age_q <= '0;
    else if (age_q != AGE_MAX) age_q <= age_q + 1'b1;
  end

  // direct four-product reference, the form the datapath avoids
  function automatic logic signed [OW-1:0] direct_re(input logic signed [DW-1:0] dr,
                                                     input logic signed [DW-1:0] di,
                                                     input logic signed [CW-1:0] cr,
                                                     input logic signed [CW-1:0] ci);
    logic signed [OW-1:0] a, b, c, d;
    a = {{(OW-DW){dr[DW-1]}}, dr};
    b = {{(OW-DW){di[DW-1]}}, di};
    c = {{(OW-CW){cr[CW-1]}}, cr};
    d = {{(OW-CW){ci[CW-1]}}, ci};
    return a * c - b * d;
  endfunction

  function automatic logic signed [OW-1:0] direct_im(input logic signed [DW-1:0] dr,
                                                     input logic signed [DW-1:0] di,
                                                     input logic signed [CW-1:0] cr,
                                                     input logic signed [CW-1:0] ci);
    logic signed [OW-1:0] a, b, c, d;
    a = {{(OW-DW){dr[DW-1]}}, dr};
    b = {{(OW-DW){di[DW-1]}}, di};
    c = {{(OW-CW){cr[CW-1]}}, cr};
    d = {{(OW-CW){ci[CW-1]}}, ci};
    return a * d + b * c;
  endfunction

  // R2: real part equals the four-product form of the operands three cycles back
  assert_real_part_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && (age_q == AGE_MAX)
    |-> r_re == direct_re($past(d_re, 3), $past(d_im, 3), $past(c_re, 3), $past(c_im, 3)));

  // R1: imaginary part equals the sum of cross products three cycles back
  assert_imag_part_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid && (age_q == AGE_MAX)
    |-> r_im == direct_im($past(d_re, 3), $past(d_im, 3), $past(c_re, 3), $past(c_im, 3)));

  // R5: the output strobe repeats the input strobe after the fixed latency
  assert_fixed_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (age_q == AGE_MAX) |-> out_valid == $past(in_valid, 3));

  // R7: with no result retiring, the output words do not move
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (age_q >= AGEW'(2)) && !out_valid |-> $stable(r_re) && $stable(r_im));

  // R8: during reset the result strobe stays low
  assert_reset_quiet_R8: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

endmodule

// File: tb/cmul3_tb_top.sv
module cmul3_tb_top;

  localparam int  DW       = 16;
  localparam int  CW       = 16;
  localparam int  OW       = DW + CW + 2;
  localparam time CLK_HALF = 5ns;
  localparam int  WATCHDOG = 100000;

  logic                 clk = 1'b0;
  logic                 rst;
  logic                 in_valid;
  logic signed [DW-1:0] d_re, d_im;
  logic signed [CW-1:0] c_re, c_im;
  logic                 out_valid;
  logic signed [OW-1:0] r_re, r_im;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_HALF) clk = ~clk;

  cmul3 #(.DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .d_re(d_re), .d_im(d_im), .c_re(c_re), .c_im(c_im),
    .out_valid(out_valid), .r_re(r_re), .r_im(r_im)
  );

  // reference results in 64-bit integers, schoolbook form
  function automatic longint exp_real(int dr, int di, int cr, int ci);
    return longint'(dr) * longint'(cr) - longint'(di) * longint'(ci);
  endfunction

  function automatic longint exp_imag(int dr, int di, int cr, int ci);
    return longint'(dr) * longint'(ci) + longint'(di) * longint'(cr);
  endfunction

  // history of issued operand sets; index 2 is three cycles old
  logic   h_v [3];
  longint h_re[3];
  longint h_im[3];
  string  h_tag[3];
  longint last_re = 0;
  longint last_im = 0;

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, int dr, int di, int cr, int ci, string tag);
    @(negedge clk);
    // result for the set issued three negedges ago
    check("R5", "out_valid", longint'(out_valid), longint'(h_v[2]));
    if (h_v[2]) begin
      check({h_tag[2], "/R2"}, "r_re", longint'(r_re), h_re[2]);
      check({h_tag[2], "/R1"}, "r_im", longint'(r_im), h_im[2]);
      last_re = h_re[2];
      last_im = h_im[2];
    end else begin
      check("R7", "r_re hold", longint'(r_re), last_re);
      check("R7", "r_im hold", longint'(r_im), last_im);
    end
    for (int k = 2; k > 0; k--) begin
      h_v[k] = h_v[k-1]; h_re[k] = h_re[k-1]; h_im[k] = h_im[k-1]; h_tag[k] = h_tag[k-1];
    end
    h_v[0]   = v;
    h_re[0]  = exp_real(dr, di, cr, ci);
    h_im[0]  = exp_imag(dr, di, cr, ci);
    h_tag[0] = tag;
    in_valid = v;
    d_re = DW'(dr); d_im = DW'(di); c_re = CW'(cr); c_im = CW'(ci);
  endtask

  function automatic int rnd_d();
    logic signed [DW-1:0] t;
    t = DW'($urandom);
    return int'(t);
  endfunction

  function automatic int rnd_c();
    logic signed [CW-1:0] t;
    t = CW'($urandom);
    return int'(t);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int dmin, dmax, cmin, cmax;
    void'($urandom(32'd20240611));
    dmin = -(1 <<< (DW-1)); dmax = (1 <<< (DW-1)) - 1;
    cmin = -(1 <<< (CW-1)); cmax = (1 <<< (CW-1)) - 1;
    for (int k = 0; k < 3; k++) begin
      h_v[k] = 1'b0; h_re[k] = 0; h_im[k] = 0; h_tag[k] = "";
    end
    rst = 1'b1; in_valid = 1'b1;
    d_re = '1; d_im = '1; c_re = '1; c_im = '1;
    repeat (4) @(negedge clk);
    // R8: reset clears strobe and results even with in_valid held high
    check("R8", "out_valid", longint'(out_valid), 0);
    check("R8", "r_re", longint'(r_re), 0);
    check("R8", "r_im", longint'(r_im), 0);
    in_valid = 1'b0;
    rst = 1'b0;

    // R3: extreme inputs where pre-sum and pre-difference need the extra bit
    step(1, dmin, dmin, cmin, cmin, "R3");
    step(1, dmax, dmax, cmax, cmin, "R3");
    step(1, dmin, dmax, cmin, cmax, "R3");
    // R4: largest wide product magnitude, (-2^DW) * (2^CW - 1)
    step(1, dmin, dmin, cmax, cmin, "R4");
    step(1, dmax, dmax, cmin, cmax, "R4");
    step(0, 0, 0, 0, 0, "idle");
    step(1, 0, 0, 0, 0, "R1");
    step(1, 1, 0, 0, 1, "R1");
    step(1, 0, 1, 1, 0, "R2");
    // R7: operands with in_valid low must not disturb the held result
    step(0, dmax, dmin, cmax, cmin, "R7");
    step(0, 1234, -77, 9, -5, "R7");
    step(0, dmin, dmin, cmin, cmin, "R7");
    step(0, 0, 0, 0, 0, "R7");

    // constrained random: mostly valid, occasional gaps
    for (int n = 0; n < 400; n++) begin
      bit v;
      int sel;
      v   = ($urandom_range(3, 0) != 0);
      sel = $urandom_range(7, 0);
      if (sel == 0)
        step(v, dmin, rnd_d(), cmax, rnd_c(), "R3");
      else if (sel == 1)
        step(v, rnd_d(), dmax, rnd_c(), cmin, "R4");
      else
        step(v, rnd_d(), rnd_d(), rnd_c(), rnd_c(), "rand");
    end

    // R6: unbroken burst, one operand set every cycle
    for (int n = 0; n < 32; n++)
      step(1, rnd_d(), rnd_d(), rnd_c(), rnd_c(), "R6");

    for (int n = 0; n < 5; n++)
      step(0, rnd_d(), rnd_d(), rnd_c(), rnd_c(), "R7");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule